// File: doc/BRIEF.md
# Segmented Byte-Bus Access Sequencer

This block sits between a processor core and a memory that is only one byte wide. The core issues a read or a write with a 16-bit segment, a 16-bit offset, a size flag (byte or word) and up to 16 bits of write data. The block forms a 20-bit physical address by shifting the segment left four places and adding the offset. It then runs the access on the byte-wide memory.

A byte access takes one memory cycle. A word access takes two back-to-back byte cycles. The low byte uses the computed address and the high byte uses the address one above it. A word read is put back together before it is returned. Every address wraps modulo 1 MB.

The core raises a request. Busy stays high while the block works and done pulses once when the result is ready. The memory behaves as a synchronous RAM: read data shows up one cycle after its address.

Top module: `seg_byte_bridge`

## Requirements
- R1: The first memory address of an access equals (segment × 16 + offset) modulo 2^20.
- R2: A byte write drives exactly one memory write cycle, at the R1 address, carrying bits 7:0 of the write data.
- R3: A word write drives two memory write cycles in consecutive clocks. Bits 7:0 go first to the R1 address, then bits 15:8 go to that address plus one.
- R4: During the done cycle of a word read, rdata_o equals {byte at address+1, byte at R1 address}, with bits 15:8 taken from address+1.
- R5: Both the base sum and the step to the second byte wrap within 1 MB. 0xFFFFF is followed by 0x00000, and a sum of 0x100000 maps to 0x00000.
- R6: Busy rises the clock after a request is accepted and falls only after done has pulsed. Done is high for exactly one cycle. Busy lasts 2 cycles for a byte access and 3 cycles for a word access.
- R7: A request raised while busy is high, including the done cycle, is ignored. It causes no memory write and does not extend busy.
- R8: During the done cycle of a byte read, rdata_o holds the addressed byte in bits 7:0 and zero in bits 15:8.
- R9: While reset is asserted and right after it, busy_o, done_o and mem_we_o are low.
- R10: mem_we_o is high only in the memory cycles of a write access. A read drives no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when busy_o is low |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset within the segment |
| wdata_i | input | 16 | Write data, low byte in bits 7:0 |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid while done_o is high |
| mem_addr_o | output | 20 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read byte, one cycle after its address |

## Verification
Two events can fall in the same clock: the done pulse that ends one access, and a fresh request from the core. The bench raises a write request exactly in the done cycle of a word write, and also in the first busy cycle. It then judges the outcome at the ports. Busy must fall on schedule, no extra memory write may appear, and a later read of the target byte must still return its old value. A second coincidence is handled the same way: the step to the high byte is made at the top of the address space, so the increment and the 1 MB wrap happen together.

// File: rtl/seg_bridge_pkg.sv
package seg_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] next_o
);
  localparam int SUM_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1;

  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  assign seg_ext = SUM_W'(seg_i) << SHIFT;
  assign off_ext = SUM_W'(off_i);
  assign sum     = seg_ext + off_ext;
  // carries above ADDR_W are dropped: wrap within the address space
  assign base_o  = sum[ADDR_W-1:0];
  assign next_o  = base_o + ADDR_W'(1);
endmodule

// File: rtl/seg_byte_fsm.sv
module seg_byte_fsm
  import seg_bridge_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       word_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       word_o
);
  seq_state_e state_q, state_d;
  logic       word_q;

  assign accept_o = req_i && (state_q == ST_IDLE);
  assign state_o  = state_q;
  assign word_o   = word_q;

  always_comb begin
    unique case (state_q)
      ST_IDLE: state_d = accept_o ? ST_LO : ST_IDLE;
      ST_LO:   state_d = word_q ? ST_HI : ST_FIN;
      ST_HI:   state_d = ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) word_q <= word_i;
    end
  end
endmodule

// File: rtl/seg_word_pack.sv
module seg_word_pack
  import seg_bridge_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  seq_state_e          state_i,
  input  logic                word_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0]   mem_rdata_i,
  output logic [BYTE_W-1:0]   wbyte_o,
  output logic [2*BYTE_W-1:0] rdata_o
);
  localparam int LANES = 2;

  logic [LANES-1:0]  lane_sel;
  logic [BYTE_W-1:0] lane_w [LANES];
  logic [BYTE_W-1:0] lo_q;

  assign lane_sel[0] = (state_i != ST_HI);
  assign lane_sel[1] = (state_i == ST_HI);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_w[i] = lane_sel[i] ? wdata_i[i*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    wbyte_o = '0;
    for (int i = 0; i < LANES; i++) wbyte_o |= lane_w[i];
  end

  // low byte of a word read arrives while the high address is presented
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lo_q <= '0;
    else if (state_i == ST_HI)   lo_q <= mem_rdata_i;
  end

  always_comb begin
    if (state_i != ST_FIN) rdata_o = '0;
    else if (word_i)       rdata_o = {mem_rdata_i, lo_q};
    else                   rdata_o = {{BYTE_W{1'b0}}, mem_rdata_i};
  end
endmodule

// File: rtl/seg_byte_bridge.sv
module seg_byte_bridge
  import seg_bridge_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic [SEG_W-1:0]    seg_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [BYTE_W-1:0]   mem_wdata_o,
  output logic                mem_we_o,
  input  logic [BYTE_W-1:0]   mem_rdata_i
);
  localparam int WORD_W = 2 * BYTE_W;

  seq_state_e          state;
  logic                accept;
  logic                word_q;
  logic                we_q;
  logic [ADDR_W-1:0]   base_d, next_d, base_q, next_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [BYTE_W-1:0]   wbyte;
  logic                mem_cycle;

  seg_addr_gen #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT),
    .ADDR_W(ADDR_W)
  ) u_addr (
    .seg_i (seg_i),
    .off_i (off_i),
    .base_o(base_d),
    .next_o(next_d)
  );

  seg_byte_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .word_i  (word_i),
    .state_o (state),
    .accept_o(accept),
    .word_o  (word_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      base_q  <= '0;
      next_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= we_i;
      base_q  <= base_d;
      next_q  <= next_d;
      wdata_q <= wdata_i;
    end
  end

  seg_word_pack #(
    .BYTE_W(BYTE_W)
  ) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .word_i     (word_q),
    .wdata_i    (wdata_q),
    .mem_rdata_i(mem_rdata_i),
    .wbyte_o    (wbyte),
    .rdata_o    (rdata_o)
  );

  assign mem_cycle   = (state == ST_LO) || (state == ST_HI);
  assign mem_we_o    = mem_cycle && we_q;
  assign mem_addr_o  = (state == ST_HI) ? next_q : base_q;
  assign mem_wdata_o = mem_we_o ? wbyte : '0;
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_FIN);
endmodule

// File: rtl/seg_byte_bridge_chk.sv
module seg_byte_bridge_chk #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [SEG_W-1:0]  seg_i,
  input logic [OFF_W-1:0]  off_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [31:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 exp_q <= '0;
    else if (req_i && !busy_o)   exp_q <= (32'(seg_i) << SHIFT) + 32'(off_i);
  end

  p_base_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$past(busy_o) |-> mem_addr_o == exp_q[ADDR_W-1:0]);

  // high byte cycle of a word: busy, not done, and not the first busy cycle
  p_next_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && $past(busy_o) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(busy_o) |-> $past(done_o));

  p_done_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_we_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o && !done_o);
endmodule

bind seg_byte_bridge seg_byte_bridge_chk #(
  .SEG_W (SEG_W),
  .OFF_W (OFF_W),
  .SHIFT (SHIFT),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .seg_i     (seg_i),
  .off_i     (off_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/seg_byte_bridge_tb_top.sv
module seg_byte_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, word = 1'b0;
  logic [15:0] seg = '0, off = '0, wdata = '0;
  logic        busy, done, mem_we;
  logic [15:0] rdata;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0]  mem [logic [19:0]];
  logic [19:0] wr_addr_q [$];
  logic [7:0]  wr_data_q [$];

  always #4 clk = ~clk;

  seg_byte_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .seg_i(seg), .off_i(off), .wdata_i(wdata), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  // synchronous byte RAM plus write log
  always @(posedge clk) begin
    mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_addr_q.push_back(mem_addr);
      wr_data_q.push_back(mem_wdata);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inject: 0 none, 1 during first busy cycle, 2 during done cycle
  task automatic access(input logic w, input logic wd, input logic [15:0] s,
                        input logic [15:0] o, input logic [15:0] d, input int inject,
                        output logic [15:0] rd, output int ncyc);
    wr_addr_q.delete();
    wr_data_q.delete();
    rd = '0;
    ncyc = 0;
    @(negedge clk);
    req = 1'b1; we = w; word = wd; seg = s; off = o; wdata = d;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (busy) ncyc++;
      if ((inject == 1 && ncyc == 1) || (inject == 2 && done)) begin
        req = 1'b1; we = 1'b1; word = 1'b0; seg = 16'h0010; off = 16'h0000; wdata = 16'h0077;
      end else begin
        req = 1'b0;
      end
      if (done) begin
        rd = rdata;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 busy after reset", 32'(busy), 0);
    check("R9 done after reset", 32'(done), 0);
    check("R9 we after reset", 32'(mem_we), 0);
  endtask

  task automatic t_byte_write;
    logic [15:0] rd; int n;
    access(1, 0, 16'h1234, 16'h0005, 16'h99A5, 0, rd, n);
    check("R6 byte busy cycles", n, 2);
    check("R2 R10 byte write count", wr_addr_q.size(), 1);
    if (wr_addr_q.size() > 0) begin
      check("R1 R2 byte write addr", 32'(wr_addr_q[0]), 32'h12345);
      check("R2 byte write data", 32'(wr_data_q[0]), 32'hA5);
    end
  endtask

  task automatic t_byte_read;
    logic [15:0] rd; int n;
    access(0, 0, 16'h1230, 16'h0045, 16'hFFFF, 0, rd, n);
    check("R8 byte read data", 32'(rd), 32'h00A5);
    check("R10 read makes no write", wr_addr_q.size(), 0);
    check("R6 byte read busy cycles", n, 2);
  endtask

  task automatic t_word_write_read;
    logic [15:0] rd; int n;
    access(1, 1, 16'hA000, 16'h5F00, 16'hBEEF, 0, rd, n);
    check("R6 word busy cycles", n, 3);
    check("R3 word write count", wr_addr_q.size(), 2);
    if (wr_addr_q.size() == 2) begin
      check("R3 first addr", 32'(wr_addr_q[0]), 32'hA5F00);
      check("R3 first data", 32'(wr_data_q[0]), 32'hEF);
      check("R3 second addr", 32'(wr_addr_q[1]), 32'hA5F01);
      check("R3 second data", 32'(wr_data_q[1]), 32'hBE);
    end
    access(0, 1, 16'hA5F0, 16'h0000, 16'h0000, 0, rd, n);
    check("R4 word read data", 32'(rd), 32'hBEEF);
    check("R10 word read no write", wr_addr_q.size(), 0);
  endtask

  task automatic t_wrap;
    logic [15:0] rd; int n;
    access(1, 1, 16'hF000, 16'hFFFF, 16'hCAFE, 0, rd, n);
    if (wr_addr_q.size() == 2) begin
      check("R5 low at top", 32'(wr_addr_q[0]), 32'hFFFFF);
      check("R5 high wraps", 32'(wr_addr_q[1]), 32'h00000);
    end else check("R5 wrap write count", wr_addr_q.size(), 2);
    access(0, 0, 16'hFFFF, 16'h0010, 16'h0000, 0, rd, n);
    check("R5 base sum wraps", 32'(rd), 32'h00CA);
    access(0, 1, 16'hFFFF, 16'hFFFF, 16'h0000, 0, rd, n);
    check("R1 wrapped word read", 32'(rd), {16'h0, mem.exists(20'h0FFF0) ? mem[20'h0FFF0] : 8'h00,
                                            mem.exists(20'h0FFEF) ? mem[20'h0FFEF] : 8'h00});
    access(0, 1, 16'hF000, 16'hFFFF, 16'h0000, 0, rd, n);
    check("R4 R5 word read across top", 32'(rd), 32'hCAFE);
  endtask

  task automatic t_ignore;
    logic [15:0] rd; int n;
    access(1, 1, 16'h0200, 16'h0002, 16'h1122, 1, rd, n);
    check("R7 busy not extended (first cycle)", n, 3);
    check("R7 only own writes (first cycle)", wr_addr_q.size(), 2);
    check("R7 idle after", 32'(busy), 0);
    access(1, 1, 16'h0200, 16'h0004, 16'h3344, 2, rd, n);
    check("R7 busy not extended (done cycle)", n, 3);
    check("R7 idle after done-cycle request", 32'(busy), 0);
    check("R7 only own writes (done cycle)", wr_addr_q.size(), 2);
    access(0, 0, 16'h0010, 16'h0000, 16'h0000, 0, rd, n);
    check("R7 target byte untouched", 32'(rd), 32'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_byte_read();
    t_word_write_read();
    t_wrap();
    t_ignore();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule